// File: doc/BRIEF.md
# Gamma Brightness Table Loader

This block turns a brightness level request into the command traffic that retunes an emissive display panel. A level does not set a duty cycle. It selects a whole gamma curve of 23 bytes, which the block streams one byte per handshake to a downstream panel command writer. After the curve, the block sends a short two-byte activation transaction, and only then does the new curve take effect.

The curves come from an internal ROM that is computed from the level and the byte position, so the block needs no stored table. Each output byte carries a flag that marks the command byte at the start of a transaction. The writer can report that a byte failed to go out. When that happens the block abandons the rest of the transfer and raises an error pulse. A clean finish raises a done pulse and updates the reported active level. One request can wait while an upload runs, and it is started as soon as the current activation transaction is over.

Top module: `gamma_table_loader`

## Requirements
- R1: After reset `out_valid`, `done` and `error` are low and `active_level` is 10.
- R2: A requested level above 10 is treated as level 10, both for the bytes sent and for `active_level`.
- R3: The upload starts with a 23-byte record. Byte 0 is the command 0xFA with `out_first` high. Bytes 1 to 4 are 0x00, 0x18, 0x08 and 0x24. Each byte i from 5 to 22 equals (0x40 + 4*i + 3*L) mod 256, where L is the clamped level.
- R4: The activation transaction follows the record directly. It is two bytes: 0xFA with `out_first` high, then 0x01 with `out_first` low.
- R5: A byte transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_first` hold.
- R6: `done` pulses for one cycle, in the cycle after the final activation byte is accepted. From that cycle on, `active_level` shows the uploaded level.
- R7: If `wr_err` is high on an accepted byte, no further bytes of that upload are offered. `error` pulses in the next cycle, `done` does not pulse, and `active_level` keeps its old value.
- R8: A request that arrives during an upload is held. It is started after the current activation transaction completes.
- R9: `out_first` is high only on the two command bytes, which are record byte 0 and activation byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle brightness request strobe |
| req_level | input | 4 | Requested brightness level |
| out_valid | output | 1 | A byte is offered downstream |
| out_data | output | 8 | Offered byte |
| out_first | output | 1 | Offered byte is a command byte |
| out_ready | input | 1 | Downstream accepts the offered byte |
| wr_err | input | 1 | Accepted byte failed to go out |
| done | output | 1 | Upload and activation completed |
| error | output | 1 | Upload aborted by a write failure |
| busy | output | 1 | Upload or activation in progress |
| active_level | output | 4 | Last level fully applied |

## Verification
A wrong byte index or a wrong level register shows up at `out_data` on the very byte it corrupts. So every accepted byte is compared against the closed-form record, and an off-by-one in the sequencing is caught within one transfer. A wrong state after a failure would show up as extra offered bytes or a stray `done`. The cycles right after `error` are therefore watched for silence on `out_valid`. A lost held request would show up as a missing second stream after the first `done`.

// File: rtl/gamma_table_loader.sv
module gamma_table_loader #(
  parameter int LEVELS = 11,
  parameter int LVL_W = 4,
  parameter int REC_LEN = 23,
  parameter logic [7:0] GAMMA_CMD = 8'hFA,
  parameter logic [7:0] LATCH_ARG = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  input  logic             out_ready,
  input  logic             wr_err,
  output logic             done,
  output logic             error,
  output logic             busy,
  output logic [LVL_W-1:0] active_level
);
  localparam int MAXLVL = LEVELS - 1;
  localparam int IDX_W = $clog2(REC_LEN);
  localparam logic [LVL_W-1:0] MAX_L = LVL_W'(MAXLVL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_GAMMA, S_LATCH} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic [LVL_W-1:0] lvl, pend_lvl, act_q;
  logic             pend_v, done_q, err_q;

  function automatic logic [7:0] rom_byte(input logic [LVL_W-1:0] l, input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0): rom_byte = GAMMA_CMD;
      IDX_W'(1): rom_byte = 8'h00;
      IDX_W'(2): rom_byte = 8'h18;
      IDX_W'(3): rom_byte = 8'h08;
      IDX_W'(4): rom_byte = 8'h24;
      default:   rom_byte = 8'(32'h40 + 4 * int'(i) + 3 * int'(l));
    endcase
  endfunction

  wire [LVL_W-1:0] req_clamped = (req_level > MAX_L) ? MAX_L : req_level;
  wire fire = out_valid && out_ready;
  wire last = (state == S_GAMMA && idx == LAST_IDX) ||
              (state == S_LATCH && idx == IDX_W'(1));

  assign out_valid = (state != S_IDLE);
  assign busy = out_valid;
  assign out_first = out_valid && (idx == '0);
  assign out_data = (state == S_LATCH) ? ((idx == '0) ? GAMMA_CMD : LATCH_ARG)
                                       : rom_byte(lvl, idx);
  assign done = done_q;
  assign error = err_q;
  assign active_level = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      lvl <= '0;
      pend_v <= 1'b0;
      pend_lvl <= '0;
      done_q <= 1'b0;
      err_q <= 1'b0;
      act_q <= MAX_L;
    end else begin
      done_q <= 1'b0;
      err_q <= 1'b0;
      if (state == S_IDLE) begin
        if (pend_v) begin
          state <= S_GAMMA;
          idx <= '0;
          lvl <= pend_lvl;
          pend_v <= 1'b0;
        end
      end else if (fire) begin
        if (wr_err) begin
          state <= S_IDLE;
          err_q <= 1'b1;
        end else if (last) begin
          idx <= '0;
          if (state == S_GAMMA) begin
            state <= S_LATCH;
          end else begin
            state <= S_IDLE;
            done_q <= 1'b1;
            act_q <= lvl;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (req_valid) begin
        pend_v <= 1'b1;
        pend_lvl <= req_clamped;
      end
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first));
  // R3
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first && out_data == GAMMA_CMD);
  // R6
  done_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fire) && $past(out_data) == LATCH_ARG && !$past(wr_err));
  // R7
  error_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $past(fire && wr_err) && !out_valid && !done);
  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_level <= MAX_L);
endmodule

// File: tb/test_gamma_table_loader.sv
module test_gamma_table_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_level = '0;
  logic out_valid, out_first, done, error, busy;
  logic [7:0] out_data;
  logic out_ready = 1'b0;
  logic wr_err = 1'b0;
  logic [3:0] active_level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  gamma_table_loader i_gamma_table_loader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_ready(out_ready), .wr_err(wr_err), .done(done), .error(error),
    .busy(busy), .active_level(active_level));

  always #10 clk = ~clk;

  // level, error byte (99 = none), stall pattern
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{0, 99, 0}, '{10, 99, 1}, '{13, 99, 0},
    '{5, 99, 1}, '{15, 99, 0}, '{7, 99, 0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clampl(input int l);
    return (l > 10) ? 10 : l;
  endfunction

  function automatic int exp_byte(input int l, input int n);
    case (n)
      0, 23: return 'hFA;
      24: return 'h01;
      1: return 'h00;
      2: return 'h18;
      3: return 'h08;
      4: return 'h24;
      default: return ('h40 + 4 * n + 3 * l) & 'hFF;
    endcase
  endfunction

  task automatic send_req(input int l);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = 4'(l);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input int l, input int err_at, input bit stall,
                         input int req_at, input int req_l, input int old_lvl);
    int n = 0;
    int k = 0;
    bit got_done = 0;
    bit got_err = 0;
    int cl = clampl(l);
    logic [7:0] held;
    bit was_stalled = 0;
    while (k < 400 && !got_done && !got_err) begin
      out_ready = stall ? k[0] : 1'b1;
      wr_err = (n == err_at);
      req_valid = (n == req_at && out_valid && out_ready);
      req_level = 4'(req_l);
      #1;
      if (was_stalled && out_valid)
        check(out_data == held, "R5 hold", out_data, held);
      was_stalled = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        check(out_data == 8'(exp_byte(cl, n)), (n < 23) ? "R3 byte" : "R4 byte",
              out_data, exp_byte(cl, n));
        check(out_first == (n == 0 || n == 23), "R9 first flag", out_first, (n == 0 || n == 23));
        n++;
      end
      @(negedge clk);
      req_valid = 1'b0;
      k++;
      if (done) got_done = 1;
      if (error) got_err = 1;
    end
    out_ready = 1'b0;
    wr_err = 1'b0;
    if (err_at == 99) begin
      check(got_done && n == 25, "R6 done after 25 bytes", n, 25);
      check(active_level == 4'(cl), "R6/R2 active level", active_level, cl);
    end else begin
      check(got_err && !got_done, "R7 error pulse", got_err, 1);
      check(n == err_at + 1, "R7 bytes skipped", n, err_at + 1);
      check(active_level == 4'(old_lvl), "R7 level kept", active_level, old_lvl);
      check(!out_valid, "R7 silent after error", out_valid, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check(!out_valid && !done && !error, "R1 reset outputs", {out_valid, done, error}, 0);
    check(active_level == 4'd10, "R1 reset level", active_level, 10);

    for (int v = 0; v < NVEC; v++) begin
      send_req(VEC[v][0]);
      collect(VEC[v][0], VEC[v][1], VEC[v][2] != 0, -1, 0, 0);
    end

    // R7: failure inside record, then inside activation
    send_req(3);
    collect(3, 7, 0, -1, 0, 7);
    send_req(4);
    collect(4, 23, 1, -1, 0, 7);

    // R8: request during upload is held and served next
    send_req(2);
    collect(2, 99, 0, 10, 12, 0);
    collect(12, 99, 1, -1, 0, 0);
    check(active_level == 4'd10, "R8 held request applied", active_level, 10);

    // R2: max level clamp at boundary
    send_req(11);
    collect(11, 99, 0, -1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule